// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Register File

This block is the software-facing register file of a camera serial receiver. An AXI4-Lite slave port reaches a small set of 32-bit registers. They hold the receiver's enable and soft-reset controls and its active-lane selection. A status word shows a long-packet counter next to the live FIFO and line-buffer flags. An interrupt status register collects single-cycle event pulses from the datapath. Interrupt enable and global enable registers gate the one interrupt line.

Two small state machines serve the bus. The write machine has the states WR_IDLE, WR_HAVE_ADDR, WR_HAVE_DATA and WR_RESP:
- From WR_IDLE it goes to WR_RESP when address and data arrive together.
- From WR_IDLE it goes to WR_HAVE_ADDR when only the address arrives, and to WR_HAVE_DATA when only the data arrives.
- From either half state it goes to WR_RESP when the missing half arrives.
- From WR_RESP it goes back to WR_IDLE when bready is high.

The read machine has the states RD_IDLE and RD_RESP. It goes from RD_IDLE to RD_RESP when a read address is accepted, and back to RD_IDLE when rready is high. Decoding uses the low seven address bits only, write strobes are ignored, and every access completes with an OKAY response. All inputs are taken to be in the register clock domain.

Top module: `cam_rx_csr`

## Requirements
- R1: After reset, offset 0x00 reads 0x1 and offset 0x04 reads {max-lane code at [4:3], max-lane code at [1:0]}. Offsets 0x10, 0x20, 0x24 and 0x28 read 0 and irq is low. The max-lane code is MAX_LANES-1.
- R2: Only address bits [6:0] are decoded, so 0x80+x aliases x. Write strobes have no effect on what is written. Undefined offsets read 0, ignore writes and answer OKAY (resp 2'b00).
- R3: At offset 0x00, bit 0 is core enable and drives core_en. Bit 1 is soft reset and drives soft_rst.
- R4: While soft reset is 1, the global enable, the interrupt enable register, the interrupt status register and the packet count are held at 0. Writes to them are ignored. Control and active lanes keep their values.
- R5: At offset 0x04, bits [1:0] are the read/write active-lane code (0..3 for 1..4 lanes) and drive active_lanes. Bits [4:3] read the fixed max-lane code, and writes to them are ignored.
- R6: At offset 0x10, bits [31:16] count ev_long_pkt pulses and stop at 0xFFFF without wrapping. Bits 3, 2, 1 and 0 show lv_spkt_full, lv_spkt_nempty, lv_lbuf_full and lv_rst_busy.
- R7: The interrupt status register at 0x24 latches event pulses into sticky bits as follows. Bit 31 is frame end and bit 22 is word-count short. Bits 20, 19, 18 and 17 are short FIFO full, short FIFO not-empty, line buffer full and stop state. Bits 13, 12 and 11 are start error, start sync error and double header error.
- R8: Writing 1 to an interrupt status bit clears it and writing 0 leaves it. When a set event and a clearing write meet in one cycle, the bit stays set.
- R9: Status bit 21 is set in every cycle in which the active-lane code exceeds the max-lane code.
- R10: irq = global enable (0x20 bit 0) AND any (status AND enable at 0x28, same bit layout). irq is low whenever the global enable is 0.
- R11: Reserved and unimplemented bits read 0, and writes to them are ignored.
- R12: A write's address and data are accepted in either order or together. Each write gets exactly one response. bvalid and rvalid stay high until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Register clock |
| aresetn | input | 1 | Active-low asynchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ev_long_pkt | input | 1 | Pulse per long packet written |
| ev_frame_end | input | 1 | Frame end received pulse |
| ev_wc_short | input | 1 | Fewer payload bytes than the word count |
| ev_spkt_full | input | 1 | Short packet FIFO became full |
| ev_spkt_nempty | input | 1 | Short packet FIFO became non-empty |
| ev_lbuf_full | input | 1 | Line buffer became full |
| ev_stop_state | input | 1 | Lane entered stop state |
| ev_sot_err | input | 1 | Start-of-transmission error |
| ev_sot_sync_err | input | 1 | Start-of-transmission sync error |
| ev_ecc_double | input | 1 | Uncorrectable header error |
| lv_spkt_full | input | 1 | Short packet FIFO full level |
| lv_spkt_nempty | input | 1 | Short packet FIFO not-empty level |
| lv_lbuf_full | input | 1 | Line buffer full level |
| lv_rst_busy | input | 1 | Reset or disable in progress |
| core_en | output | 1 | Receiver enable |
| soft_rst | output | 1 | Receiver soft reset |
| active_lanes | output | 2 | Active lane code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is an event pulse that lands on the same clock edge as the write-1-to-clear write to its own status bit. The write must commit in exactly that cycle. The bench forks the write with a pulse that starts on the same falling edge. Since the write machine sits in WR_IDLE with address and data presented together, both reach the register on the next rising edge. A second hard case is the counter's stop at 0xFFFF. The bench reaches it by holding the packet event high for more than 65,535 cycles. It then shows that soft reset brings the counter back to 0.

// File: rtl/cam_rx_csr_pkg.sv
package cam_rx_csr_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned OFS_W  = 7;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned LANE_W = 2;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 7'h00;
    localparam logic [OFS_W-1:0] OFS_LANES = 7'h04;
    localparam logic [OFS_W-1:0] OFS_STAT  = 7'h10;
    localparam logic [OFS_W-1:0] OFS_GIE   = 7'h20;
    localparam logic [OFS_W-1:0] OFS_ISR   = 7'h24;
    localparam logic [OFS_W-1:0] OFS_IER   = 7'h28;

    localparam int unsigned B_FRAME = 31;
    localparam int unsigned B_WCS   = 22;
    localparam int unsigned B_LANE  = 21;
    localparam int unsigned B_SFULL = 20;
    localparam int unsigned B_SNEMP = 19;
    localparam int unsigned B_LBUF  = 18;
    localparam int unsigned B_STOP  = 17;
    localparam int unsigned B_SOT   = 13;
    localparam int unsigned B_SYNC  = 12;
    localparam int unsigned B_ECC2  = 11;

    localparam logic [DW-1:0] ISR_IMPL =
        (DW'(1) << B_FRAME) | (DW'(1) << B_WCS)   | (DW'(1) << B_LANE) |
        (DW'(1) << B_SFULL) | (DW'(1) << B_SNEMP) | (DW'(1) << B_LBUF) |
        (DW'(1) << B_STOP)  | (DW'(1) << B_SOT)   | (DW'(1) << B_SYNC) |
        (DW'(1) << B_ECC2);

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_HAVE_ADDR,
        WR_HAVE_DATA,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

endpackage

// File: rtl/cam_rx_csr_wr_fsm.sv
module cam_rx_csr_wr_fsm
    import cam_rx_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] awofs,
    input  logic             awvalid,
    output logic             awready,
    input  logic [DW-1:0]    wdata,
    input  logic             wvalid,
    output logic             wready,
    output logic [1:0]       bresp,
    output logic             bvalid,
    input  logic             bready,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_ofs,
    output logic [DW-1:0]    wr_data
);

    wr_state_e        state_q, state_d;
    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            data_q <= '0;
        end else begin
            if (awvalid && awready) ofs_q  <= awofs;
            if (wvalid && wready)   data_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (awvalid && wvalid) state_d = WR_RESP;
                else if (awvalid)      state_d = WR_HAVE_ADDR;
                else if (wvalid)       state_d = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (wvalid)  state_d = WR_RESP;
            WR_HAVE_DATA: if (awvalid) state_d = WR_RESP;
            WR_RESP:      if (bready)  state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        wr_en   = 1'b0;
        wr_ofs  = awofs;
        wr_data = wdata;
        unique case (state_q)
            WR_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
                wr_en   = awvalid && wvalid;
            end
            WR_HAVE_ADDR: begin
                wready = 1'b1;
                wr_en  = wvalid;
                wr_ofs = ofs_q;
            end
            WR_HAVE_DATA: begin
                awready = 1'b1;
                wr_en   = awvalid;
                wr_data = data_q;
            end
            WR_RESP: bvalid = 1'b1;
        endcase
    end

    assign bresp = 2'b00;

endmodule

// File: rtl/cam_rx_csr_rd_fsm.sv
module cam_rx_csr_rd_fsm
    import cam_rx_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] arofs,
    input  logic             arvalid,
    output logic             arready,
    output logic [DW-1:0]    rdata,
    output logic [1:0]       rresp,
    output logic             rvalid,
    input  logic             rready,
    output logic [OFS_W-1:0] rd_ofs,
    input  logic [DW-1:0]    rd_word
);

    rd_state_e     state_q, state_d;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                data_q <= '0;
        else if (state_q == RD_IDLE && arvalid)    data_q <= rd_word;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_RESP;
            RD_RESP: if (rready)  state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            RD_IDLE: arready = 1'b1;
            RD_RESP: rvalid  = 1'b1;
        endcase
    end

    assign rd_ofs = arofs;
    assign rdata  = data_q;
    assign rresp  = 2'b00;

endmodule

// File: rtl/cam_rx_csr_bank.sv
module cam_rx_csr_bank
    import cam_rx_csr_pkg::*;
#(
    parameter int unsigned MAX_LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DW-1:0]     wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DW-1:0]     rd_word,
    input  logic              ev_long_pkt,
    input  logic              ev_frame_end,
    input  logic              ev_wc_short,
    input  logic              ev_spkt_full,
    input  logic              ev_spkt_nempty,
    input  logic              ev_lbuf_full,
    input  logic              ev_stop_state,
    input  logic              ev_sot_err,
    input  logic              ev_sot_sync_err,
    input  logic              ev_ecc_double,
    input  logic              lv_spkt_full,
    input  logic              lv_spkt_nempty,
    input  logic              lv_lbuf_full,
    input  logic              lv_rst_busy,
    output logic              core_en,
    output logic              soft_rst,
    output logic [LANE_W-1:0] active_lanes,
    output logic              gie,
    output logic [DW-1:0]     ier,
    output wire  [DW-1:0]     isr,
    output logic [CNT_W-1:0]  pkt_cnt,
    output logic              irq
);

    localparam logic [LANE_W-1:0] MAX_ENC  = LANE_W'(MAX_LANES - 1);
    localparam logic [CNT_W-1:0]  CNT_TOP  = {CNT_W{1'b1}};

    logic              en_q, srst_q, gie_q;
    logic [LANE_W-1:0] lanes_q;
    logic [DW-1:0]     ier_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DW-1:0]     set_vec, clr_vec;
    logic              wr_ctrl, wr_lanes, wr_gie, wr_isr, wr_ier;
    logic              lane_bad;

    assign wr_ctrl  = wr_en && (wr_ofs == OFS_CTRL);
    assign wr_lanes = wr_en && (wr_ofs == OFS_LANES);
    assign wr_gie   = wr_en && (wr_ofs == OFS_GIE);
    assign wr_isr   = wr_en && (wr_ofs == OFS_ISR);
    assign wr_ier   = wr_en && (wr_ofs == OFS_IER);
    assign lane_bad = lanes_q > MAX_ENC;

    // control and lane registers survive soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b1;
            srst_q  <= 1'b0;
            lanes_q <= MAX_ENC;
        end else begin
            if (wr_ctrl) begin
                en_q   <= wr_data[0];
                srst_q <= wr_data[1];
            end
            if (wr_lanes) lanes_q <= wr_data[LANE_W-1:0];
        end
    end

    // soft-reset domain: enables and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= '0;
            cnt_q <= '0;
        end else if (srst_q) begin
            gie_q <= 1'b0;
            ier_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_gie) gie_q <= wr_data[0];
            if (wr_ier) ier_q <= wr_data & ISR_IMPL;
            if (ev_long_pkt && (cnt_q != CNT_TOP)) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        set_vec          = '0;
        set_vec[B_FRAME] = ev_frame_end;
        set_vec[B_WCS]   = ev_wc_short;
        set_vec[B_LANE]  = lane_bad;
        set_vec[B_SFULL] = ev_spkt_full;
        set_vec[B_SNEMP] = ev_spkt_nempty;
        set_vec[B_LBUF]  = ev_lbuf_full;
        set_vec[B_STOP]  = ev_stop_state;
        set_vec[B_SOT]   = ev_sot_err;
        set_vec[B_SYNC]  = ev_sot_sync_err;
        set_vec[B_ECC2]  = ev_ecc_double;
        clr_vec          = wr_isr ? wr_data : '0;
    end

    // one sticky flop per implemented status bit; set beats clear
    for (genvar b = 0; b < DW; b++) begin : g_isr
        if (ISR_IMPL[b]) begin : g_flop
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          q <= 1'b0;
                else if (srst_q)     q <= 1'b0;
                else if (set_vec[b]) q <= 1'b1;
                else if (clr_vec[b]) q <= 1'b0;
            end
            assign isr[b] = q;
        end else begin : g_rsvd
            assign isr[b] = 1'b0;
        end
    end

    always_comb begin
        case (rd_ofs)
            OFS_CTRL:  rd_word = {30'b0, srst_q, en_q};
            OFS_LANES: rd_word = {27'b0, MAX_ENC, 1'b0, lanes_q};
            OFS_STAT:  rd_word = {cnt_q, 12'b0, lv_spkt_full, lv_spkt_nempty,
                                  lv_lbuf_full, lv_rst_busy};
            OFS_GIE:   rd_word = {31'b0, gie_q};
            OFS_ISR:   rd_word = isr;
            OFS_IER:   rd_word = ier_q;
            default:   rd_word = '0;
        endcase
    end

    assign core_en      = en_q;
    assign soft_rst     = srst_q;
    assign active_lanes = lanes_q;
    assign gie          = gie_q;
    assign ier          = ier_q;
    assign pkt_cnt      = cnt_q;
    assign irq          = gie_q && |(isr & ier_q);

endmodule

// File: rtl/cam_rx_csr.sv
module cam_rx_csr
    import cam_rx_csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_LANES = 4
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              ev_long_pkt,
    input  logic              ev_frame_end,
    input  logic              ev_wc_short,
    input  logic              ev_spkt_full,
    input  logic              ev_spkt_nempty,
    input  logic              ev_lbuf_full,
    input  logic              ev_stop_state,
    input  logic              ev_sot_err,
    input  logic              ev_sot_sync_err,
    input  logic              ev_ecc_double,
    input  logic              lv_spkt_full,
    input  logic              lv_spkt_nempty,
    input  logic              lv_lbuf_full,
    input  logic              lv_rst_busy,
    output logic              core_en,
    output logic              soft_rst,
    output logic [1:0]        active_lanes,
    output logic              irq
);

    logic             wr_en;
    logic [OFS_W-1:0] wr_ofs, rd_ofs;
    logic [DW-1:0]    wr_data, rd_word;
    logic             gie_w;
    logic [DW-1:0]    ier_w;
    wire  [DW-1:0]    isr_w;
    logic [CNT_W-1:0] cnt_w;

    cam_rx_csr_wr_fsm u_wr (
        .clk     (aclk),
        .rst_n   (aresetn),
        .awofs   (s_awaddr[OFS_W-1:0]),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .wr_en   (wr_en),
        .wr_ofs  (wr_ofs),
        .wr_data (wr_data)
    );

    cam_rx_csr_rd_fsm u_rd (
        .clk     (aclk),
        .rst_n   (aresetn),
        .arofs   (s_araddr[OFS_W-1:0]),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rd_ofs  (rd_ofs),
        .rd_word (rd_word)
    );

    cam_rx_csr_bank #(.MAX_LANES(MAX_LANES)) u_bank (
        .clk             (aclk),
        .rst_n           (aresetn),
        .wr_en           (wr_en),
        .wr_ofs          (wr_ofs),
        .wr_data         (wr_data),
        .rd_ofs          (rd_ofs),
        .rd_word         (rd_word),
        .ev_long_pkt     (ev_long_pkt),
        .ev_frame_end    (ev_frame_end),
        .ev_wc_short     (ev_wc_short),
        .ev_spkt_full    (ev_spkt_full),
        .ev_spkt_nempty  (ev_spkt_nempty),
        .ev_lbuf_full    (ev_lbuf_full),
        .ev_stop_state   (ev_stop_state),
        .ev_sot_err      (ev_sot_err),
        .ev_sot_sync_err (ev_sot_sync_err),
        .ev_ecc_double   (ev_ecc_double),
        .lv_spkt_full    (lv_spkt_full),
        .lv_spkt_nempty  (lv_spkt_nempty),
        .lv_lbuf_full    (lv_lbuf_full),
        .lv_rst_busy     (lv_rst_busy),
        .core_en         (core_en),
        .soft_rst        (soft_rst),
        .active_lanes    (active_lanes),
        .gie             (gie_w),
        .ier             (ier_w),
        .isr             (isr_w),
        .pkt_cnt         (cnt_w),
        .irq             (irq)
    );

endmodule

// File: rtl/cam_rx_csr_chk.sv
module cam_rx_csr_chk
    import cam_rx_csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_LANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] awaddr,
    input logic              awvalid,
    input logic              awready,
    input logic [3:0]        wstrb,
    input logic              wvalid,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic [ADDR_W-1:0] araddr,
    input logic              arvalid,
    input logic              arready,
    input logic              rvalid,
    input logic              rready,
    input logic [1:0]        rresp,
    input logic              soft_rst,
    input logic [1:0]        active_lanes,
    input logic              ev_frame_end,
    input logic              gie,
    input logic [DW-1:0]     ier,
    input logic [DW-1:0]     isr,
    input logic [CNT_W-1:0]  pkt_cnt,
    input logic              irq
);

    localparam logic [1:0] MAX_ENC = 2'(MAX_LANES - 1);

    // R12
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R12
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);

    // R2
    alias_rd_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready && (araddr[ADDR_W-1:OFS_W] != '0))
        |=> (rvalid && rresp == 2'b00));

    // R2
    strobe_free_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready && wvalid && wready &&
         ((wstrb != 4'hF) || (awaddr[ADDR_W-1:OFS_W] != '0)))
        |=> (bvalid && bresp == 2'b00));

    // R4
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (isr == '0 && ier == '0 && !gie && pkt_cnt == '0));

    // R6
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (pkt_cnt >= $past(pkt_cnt)));

    // R8
    frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_end && !soft_rst) |=> isr[B_FRAME]);

    // R9
    lane_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((active_lanes > MAX_ENC) && !soft_rst) |=> isr[B_LANE]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

endmodule

bind cam_rx_csr cam_rx_csr_chk #(.ADDR_W(ADDR_W), .MAX_LANES(MAX_LANES)) u_chk (
    .clk          (aclk),
    .rst_n        (aresetn),
    .awaddr       (s_awaddr),
    .awvalid      (s_awvalid),
    .awready      (s_awready),
    .wstrb        (s_wstrb),
    .wvalid       (s_wvalid),
    .wready       (s_wready),
    .bvalid       (s_bvalid),
    .bready       (s_bready),
    .bresp        (s_bresp),
    .araddr       (s_araddr),
    .arvalid      (s_arvalid),
    .arready      (s_arready),
    .rvalid       (s_rvalid),
    .rready       (s_rready),
    .rresp        (s_rresp),
    .soft_rst     (soft_rst),
    .active_lanes (active_lanes),
    .ev_frame_end (ev_frame_end),
    .gie          (gie_w),
    .ier          (ier_w),
    .isr          (isr_w),
    .pkt_cnt      (cnt_w),
    .irq          (irq)
);

// File: tb/test_cam_rx_csr.sv
module test_cam_rx_csr;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic          awvalid = 0, wvalid = 0, arvalid = 0;
    logic          bready = 1, rready = 1;
    logic [31:0]   wdata = '0;
    logic [3:0]    wstrb = 4'hF;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic ev_long = 0, ev_frame = 0, ev_wcs = 0, ev_sfull = 0, ev_snemp = 0;
    logic ev_lbuf = 0, ev_stop = 0, ev_sot = 0, ev_sync = 0, ev_ecc = 0;
    logic lv_sfull = 0, lv_snemp = 0, lv_lbuf = 0, lv_busy = 0;
    logic core_en, soft_rst, irq;
    logic [1:0] active_lanes;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_rx_csr #(.ADDR_W(AW), .MAX_LANES(2)) i_cam_rx_csr (
        .aclk(clk), .aresetn(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .ev_long_pkt(ev_long), .ev_frame_end(ev_frame), .ev_wc_short(ev_wcs),
        .ev_spkt_full(ev_sfull), .ev_spkt_nempty(ev_snemp), .ev_lbuf_full(ev_lbuf),
        .ev_stop_state(ev_stop), .ev_sot_err(ev_sot), .ev_sot_sync_err(ev_sync),
        .ev_ecc_double(ev_ecc),
        .lv_spkt_full(lv_sfull), .lv_spkt_nempty(lv_snemp), .lv_lbuf_full(lv_lbuf),
        .lv_rst_busy(lv_busy),
        .core_en(core_en), .soft_rst(soft_rst), .active_lanes(active_lanes), .irq(irq)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errors++;
                $display("FAIL R12 unexpected read data %h exp none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e || rresp !== 2'b00) begin
                    mon_errors++;
                    $display("FAIL %s read got %h/%b exp %h/00", t, rdata, rresp, e);
                end
            end
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string t);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", t, got, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        araddr  = a;
        arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    // order 0: together, 1: address first, 2: data first
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] s, input int order);
        @(negedge clk);
        if (order == 0) begin
            awaddr = a; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = 1'b1;
            while (!(awready && wready)) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
        end else if (order == 1) begin
            awaddr = a; awvalid = 1'b1;
            while (!awready) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0; wdata = d; wstrb = s; wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(negedge clk);
            wvalid = 1'b0;
        end else begin
            wdata = d; wstrb = s; wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(negedge clk);
            wvalid = 1'b0; awaddr = a; awvalid = 1'b1;
            while (!awready) @(negedge clk);
            @(negedge clk);
            awvalid = 1'b0;
        end
        while (!bvalid) @(negedge clk);
        chk({30'b0, bresp}, 32'h0, "R12 bresp");
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_frame = 1; 1: ev_wcs = 1;  2: ev_sfull = 1; 3: ev_snemp = 1;
            4: ev_lbuf = 1;  5: ev_stop = 1; 6: ev_sot = 1;   7: ev_sync = 1;
            8: ev_ecc = 1;   default: ev_long = 1;
        endcase
        @(negedge clk);
        {ev_frame, ev_wcs, ev_sfull, ev_snemp, ev_lbuf, ev_stop, ev_sot, ev_sync, ev_ecc, ev_long} = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state (max-lane code 1 with MAX_LANES=2)
        rd(12'h000, 32'h1, "R1 ctrl");
        rd(12'h004, 32'h9, "R1 lanes");
        rd(12'h010, 32'h0, "R1 status");
        rd(12'h020, 32'h0, "R1 gie");
        rd(12'h024, 32'h0, "R1 isr");
        rd(12'h028, 32'h0, "R1 ier");
        @(negedge clk);
        chk({31'b0, core_en}, 1, "R1 core_en");
        chk({31'b0, irq}, 0, "R1 irq");

        // R11 reserved bits
        wr(12'h000, 32'hFFFF_FFFD, 4'hF, 0);
        rd(12'h000, 32'h1, "R11 ctrl");
        wr(12'h020, 32'hFFFF_FFFF, 4'hF, 0);
        rd(12'h020, 32'h1, "R11 gie");
        wr(12'h028, 32'hFFFF_FFFF, 4'hF, 1);
        rd(12'h028, 32'h807E_3800, "R11 ier");

        // R2 aliasing, strobes, undefined offsets
        rd(12'h0A8, 32'h807E_3800, "R2 alias read");
        wr(12'h03C, 32'hFFFF_FFFF, 4'h0, 1);
        rd(12'h03C, 32'h0, "R2 undefined");
        wr(12'h0A0, 32'h0, 4'h0, 2);
        rd(12'h020, 32'h0, "R2 alias strobe-free write");
        wr(12'h028, 32'h0, 4'h0, 0);

        // R3 control outputs
        wr(12'h000, 32'h0, 4'hF, 2);
        @(negedge clk);
        chk({31'b0, core_en}, 0, "R3 core_en off");
        rd(12'h000, 32'h0, "R3 ctrl");
        wr(12'h000, 32'h1, 4'hF, 0);
        @(negedge clk);
        chk({31'b0, core_en}, 1, "R3 core_en on");

        // R5 lanes
        wr(12'h004, 32'hFFFF_FFE0, 4'hF, 0);
        rd(12'h004, 32'h8, "R5 lanes ro max");
        @(negedge clk);
        chk({30'b0, active_lanes}, 0, "R5 active_lanes");
        wr(12'h004, 32'h1, 4'hF, 0);
        rd(12'h004, 32'h9, "R5 lanes back");

        // R7 event latching
        for (int k = 0; k < 9; k++) pulse(k);
        rd(12'h024, 32'h805E_3800, "R7 isr bits");

        // R8 clear and set-wins
        wr(12'h024, 32'h8000_0000, 4'hF, 0);
        rd(12'h024, 32'h005E_3800, "R8 w1c");
        fork
            wr(12'h024, 32'h8040_0000, 4'hF, 0);
            begin @(negedge clk); ev_frame = 1; @(negedge clk); ev_frame = 0; end
        join
        rd(12'h024, 32'h801E_3800, "R8 set wins");
        wr(12'h024, 32'hFFFF_FFFF, 4'hF, 0);
        rd(12'h024, 32'h0, "R8 clear all");

        // R10 interrupt gating
        wr(12'h028, 32'h8000_0000, 4'hF, 0);
        pulse(0);
        chk({31'b0, irq}, 0, "R10 gie off");
        wr(12'h020, 32'h1, 4'hF, 0);
        @(negedge clk);
        chk({31'b0, irq}, 1, "R10 irq on");
        wr(12'h028, 32'h0, 4'hF, 0);
        @(negedge clk);
        chk({31'b0, irq}, 0, "R10 ier off");
        wr(12'h028, 32'h8000_0000, 4'hF, 0);
        wr(12'h024, 32'h8000_0000, 4'hF, 0);
        @(negedge clk);
        chk({31'b0, irq}, 0, "R10 isr cleared");

        // R9 illegal lane code
        wr(12'h004, 32'h3, 4'hF, 0);
        rd(12'h024, 32'h0020_0000, "R9 lane err");
        wr(12'h024, 32'h0020_0000, 4'hF, 0);
        rd(12'h024, 32'h0020_0000, "R9 stays while illegal");
        wr(12'h004, 32'h1, 4'hF, 0);
        wr(12'h024, 32'h0020_0000, 4'hF, 0);
        rd(12'h024, 32'h0, "R9 cleared");

        // R6 counter and levels
        lv_sfull = 1; lv_lbuf = 1; lv_busy = 1;
        for (int k = 0; k < 3; k++) pulse(9);
        rd(12'h010, 32'h0003_000B, "R6 count and levels");
        lv_sfull = 0; lv_lbuf = 0; lv_busy = 0; lv_snemp = 1;
        rd(12'h010, 32'h0003_0004, "R6 not-empty level");
        lv_snemp = 0;
        @(negedge clk);
        ev_long = 1;
        repeat (65540) @(negedge clk);
        ev_long = 0;
        rd(12'h010, 32'hFFFF_0000, "R6 no wrap");

        // R4 soft reset
        pulse(0);
        wr(12'h000, 32'h3, 4'hF, 1);
        @(negedge clk);
        chk({31'b0, soft_rst}, 1, "R4 soft_rst port");
        chk({31'b0, irq}, 0, "R4 irq");
        rd(12'h010, 32'h0, "R4 count");
        rd(12'h020, 32'h0, "R4 gie");
        rd(12'h024, 32'h0, "R4 isr");
        rd(12'h028, 32'h0, "R4 ier");
        rd(12'h004, 32'h9, "R4 lanes kept");
        rd(12'h000, 32'h3, "R4 ctrl kept");
        wr(12'h028, 32'hFFFF_FFFF, 4'hF, 0);
        rd(12'h028, 32'h0, "R4 ier write blocked");
        pulse(0);
        rd(12'h024, 32'h0, "R4 event blocked");
        wr(12'h000, 32'h1, 4'hF, 0);
        wr(12'h020, 32'h1, 4'hF, 0);
        rd(12'h020, 32'h1, "R4 released");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12 missing %0d read responses exp 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule